// File: doc/BRIEF.md
# Per-Unit Fault Guard for a Redundant Execution Lane

This block sits beside one functional unit of a statically scheduled, multi-issue datapath in which every operation runs twice on two different units. It keeps a small vector with one bit per operator inside the unit. A set bit marks an operator that is known to have a permanent fault. The opcode in the execute stage selects the active operator, so the block always knows whether the result now leaving the unit can be trusted.

Each scheduled slot carries a mode bit and a reference-register index. In store mode the result, tagged with a bad flag, goes to the temporary register file entry named by the index. In compare mode the result is checked against that entry. A fresh mismatch, meaning one not explained by a known fault on either side, raises a recompute request to the voting controller. Write-back to the architectural register file is held off while that request is raised and whenever the active operator is known bad.

The voting controller sets a fault bit with a one-cycle mark pulse. A compare that matches even though the active operator is marked bad clears its bit, which turns the fault into a transient one. When both sides of a compare are known bad, the block flags a double fault.

Top module: `fault_guard`

## Requirements
- R1: While reset is held and after its release, the fault vector is all zeros, and with no valid slot the outputs knownBad, trfWrEn, recomputeReq, wbEnable and doubleFault are all 0.
- R2: The active operator index is the upper OP_SEL_W bits of exOpcode, that is exOpcode >> (OPC_W - OP_SEL_W). knownBad is 1 exactly when exValid is 1 and the fault-vector bit at that index is 1.
- R3: In a valid slot with exMode = 0, trfWrEn is 1, trfWrData equals exResult, trfWrBad equals knownBad, and no recompute request is raised. trfIdx always equals exRefIdx. trfWrEn is 0 in any other slot.
- R4: In a valid slot with exMode = 1, knownBad = 0 and trfRdBad = 0, recomputeReq is 1 exactly when exResult differs from trfRdData.
- R5: When knownBad is 1, recomputeReq stays 0, even if the values mismatch.
- R6: When trfRdBad is 1, recomputeReq stays 0, even if the values mismatch.
- R7: wbEnable is 1 exactly when exValid is 1, knownBad is 0 and recomputeReq is 0.
- R8: A valid compare-mode slot with knownBad = 1, trfRdBad = 0 and equal values clears the active operator's fault bit on the next clock edge.
- R9: A mark pulse sets the fault bit named by markOp on the next clock edge. It takes priority over a clear of the same bit in the same cycle.
- R10: doubleFault is 1 exactly when a valid compare-mode slot has knownBad = 1 and trfRdBad = 1.
- R11: The fault vector changes only through R8 or R9. A slot with exValid = 0 drives every strobe to 0 and leaves the vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exValid | input | 1 | An operation occupies the execute stage |
| exOpcode | input | OPC_W | Opcode of that operation |
| exMode | input | 1 | 0 = store the result as a reference, 1 = compare with the reference |
| exRefIdx | input | IDX_W | Temporary register entry used as the reference |
| exResult | input | DATA_W | Result produced by the unit |
| trfRdData | input | DATA_W | Value read from the temporary register entry |
| trfRdBad | input | 1 | Bad flag stored with that value |
| markFault | input | 1 | One-cycle pulse from the voting controller that marks an operator faulty |
| markOp | input | OP_SEL_W | Operator index to mark |
| trfIdx | output | IDX_W | Temporary register entry address |
| trfWrEn | output | 1 | Write strobe for the temporary register file |
| trfWrData | output | DATA_W | Value to write |
| trfWrBad | output | 1 | Bad flag written with the value |
| knownBad | output | 1 | The active operator is marked faulty |
| recomputeReq | output | 1 | Fresh mismatch; asks for a third execution |
| wbEnable | output | 1 | Result may be written to the architectural register file |
| doubleFault | output | 1 | Both the own operator and the reference are known bad |
| faultVec | output | NUM_OPS | Permanent-fault vector, one bit per operator |

## Verification
The hardest state to reach is the one where a fault bit is cleared and set at once. That needs an operator that is already marked, a compare-mode slot on it with a clean, equal reference, and a mark pulse aimed at the same operator in the same cycle. A directed sequence first marks an operator and then drives exactly that collision. After that comes a plain transient clear, which shows the bit can still drop when no mark is pending. A long pseudo-random phase then mixes rare marks with compares that match about half of the time. Every clock is checked against a behavioural model.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef struct packed {
    logic trfWrite;
    logic recompute;
    logic writeBack;
    logic clearFault;
    logic dblFault;
  } guardCtl_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OPC_W    = 6,
  parameter int OP_SEL_W = 2,
  localparam int NUM_OPS = 1 << OP_SEL_W,
  localparam int LOW_W   = OPC_W - OP_SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    exOpcode,
  input  logic [DATA_W-1:0]   exResult,
  input  logic [DATA_W-1:0]   trfRdData,
  input  logic                markFault,
  input  logic [OP_SEL_W-1:0] markOp,
  input  guardCtl_t           ctl,
  output logic                opBad,
  output logic                valuesMatch,
  output logic [NUM_OPS-1:0]  faultVec
);
  logic [OP_SEL_W-1:0] opSel;

  assign opSel       = OP_SEL_W'(exOpcode >> LOW_W);
  assign opBad       = faultVec[opSel];
  assign valuesMatch = (exResult == trfRdData);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_faultBit
    logic setHit;
    logic clrHit;
    assign setHit = markFault && (markOp == OP_SEL_W'(i));
    assign clrHit = ctl.clearFault && (opSel == OP_SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      faultVec[i] <= 1'b0;
      else if (setHit) faultVec[i] <= 1'b1;
      else if (clrHit) faultVec[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_control.sv
module guard_control
  import guard_pkg::*;
(
  input  logic      exValid,
  input  logic      exMode,
  input  logic      opBad,
  input  logic      refBad,
  input  logic      valuesMatch,
  output logic      knownBad,
  output guardCtl_t ctl
);
  logic cmpSlot;
  logic cmpLive;

  assign knownBad = exValid && opBad;
  assign cmpSlot  = exValid && exMode;
  assign cmpLive  = cmpSlot && !knownBad && !refBad;

  always_comb begin
    ctl            = '0;
    ctl.trfWrite   = exValid && !exMode;
    ctl.recompute  = cmpLive && !valuesMatch;
    ctl.writeBack  = exValid && !knownBad && !ctl.recompute;
    ctl.clearFault = cmpSlot && knownBad && !refBad && valuesMatch;
    ctl.dblFault   = cmpSlot && knownBad && refBad;
  end
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import guard_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OPC_W     = 6,
  parameter int OP_SEL_W  = 2,
  parameter int TRF_DEPTH = 8,
  localparam int NUM_OPS  = 1 << OP_SEL_W,
  localparam int IDX_W    = $clog2(TRF_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exValid,
  input  logic [OPC_W-1:0]    exOpcode,
  input  logic                exMode,
  input  logic [IDX_W-1:0]    exRefIdx,
  input  logic [DATA_W-1:0]   exResult,
  input  logic [DATA_W-1:0]   trfRdData,
  input  logic                trfRdBad,
  input  logic                markFault,
  input  logic [OP_SEL_W-1:0] markOp,
  output logic [IDX_W-1:0]    trfIdx,
  output logic                trfWrEn,
  output logic [DATA_W-1:0]   trfWrData,
  output logic                trfWrBad,
  output logic                knownBad,
  output logic                recomputeReq,
  output logic                wbEnable,
  output logic                doubleFault,
  output logic [NUM_OPS-1:0]  faultVec
);
  guardCtl_t ctl;
  logic      opBad;
  logic      valuesMatch;

  guard_datapath #(.DATA_W(DATA_W), .OPC_W(OPC_W), .OP_SEL_W(OP_SEL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .exOpcode(exOpcode), .exResult(exResult),
    .trfRdData(trfRdData), .markFault(markFault), .markOp(markOp), .ctl(ctl),
    .opBad(opBad), .valuesMatch(valuesMatch), .faultVec(faultVec)
  );

  guard_control u_ctl (
    .exValid(exValid), .exMode(exMode), .opBad(opBad), .refBad(trfRdBad),
    .valuesMatch(valuesMatch), .knownBad(knownBad), .ctl(ctl)
  );

  assign trfIdx       = exRefIdx;
  assign trfWrEn      = ctl.trfWrite;
  assign trfWrData    = exResult;
  assign trfWrBad     = knownBad;
  assign recomputeReq = ctl.recompute;
  assign wbEnable     = ctl.writeBack;
  assign doubleFault  = ctl.dblFault;
endmodule

// File: rtl/fault_guard_checker.sv
module fault_guard_checker #(
  parameter int DATA_W   = 16,
  parameter int OPC_W    = 6,
  parameter int OP_SEL_W = 2,
  localparam int NUM_OPS = 1 << OP_SEL_W,
  localparam int LOW_W   = OPC_W - OP_SEL_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                exValid,
  input logic [OPC_W-1:0]    exOpcode,
  input logic                exMode,
  input logic [DATA_W-1:0]   exResult,
  input logic [DATA_W-1:0]   trfRdData,
  input logic                trfRdBad,
  input logic                markFault,
  input logic [OP_SEL_W-1:0] markOp,
  input logic                trfWrEn,
  input logic                knownBad,
  input logic                recomputeReq,
  input logic                wbEnable,
  input logic                doubleFault,
  input logic [NUM_OPS-1:0]  faultVec
);
  logic [OP_SEL_W-1:0] curSel;
  logic                clrCase;
  assign curSel  = OP_SEL_W'(exOpcode >> LOW_W);
  assign clrCase = exValid && exMode && knownBad && !trfRdBad && (exResult == trfRdData);

  assert_bad_blocks_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    knownBad |-> !wbEnable);
  assert_req_is_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    recomputeReq |-> (exValid && exMode && !trfRdBad && (exResult != trfRdData)));
  assert_known_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    knownBad |-> !recomputeReq);
  assert_store_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trfWrEn |-> !recomputeReq);
  assert_mark_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    markFault |=> faultVec[$past(markOp)]);
  assert_clear_transient_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrCase && !markFault) |=> !faultVec[$past(curSel)]);
  assert_double_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doubleFault |-> (exValid && exMode && knownBad && trfRdBad));
  assert_vec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!markFault && !clrCase) |=> $stable(faultVec));
endmodule

bind fault_guard fault_guard_checker #(
  .DATA_W(DATA_W), .OPC_W(OPC_W), .OP_SEL_W(OP_SEL_W)
) i_fault_guard_checker (
  .clk(clk), .rst_n(rst_n), .exValid(exValid), .exOpcode(exOpcode),
  .exMode(exMode), .exResult(exResult), .trfRdData(trfRdData),
  .trfRdBad(trfRdBad), .markFault(markFault), .markOp(markOp),
  .trfWrEn(trfWrEn), .knownBad(knownBad), .recomputeReq(recomputeReq),
  .wbEnable(wbEnable), .doubleFault(doubleFault), .faultVec(faultVec)
);

// File: tb/test_fault_guard.sv
`timescale 1ns/1ps
module test_fault_guard;
  localparam int DW = 16, OW = 6, SW = 2, DEPTH = 8, IW = 3, NO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exValid = 1'b0, exMode = 1'b0, trfRdBad = 1'b0, markFault = 1'b0;
  logic [OW-1:0] exOpcode = '0;
  logic [IW-1:0] exRefIdx = '0;
  logic [DW-1:0] exResult = '0, trfRdData = '0;
  logic [SW-1:0] markOp = '0;
  logic [IW-1:0] trfIdx;
  logic trfWrEn, trfWrBad, knownBad, recomputeReq, wbEnable, doubleFault;
  logic [DW-1:0] trfWrData;
  logic [NO-1:0] faultVec;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [NO-1:0] model = '0;
  string vecTag = "R1";

  always #2 clk = ~clk;

  fault_guard #(.DATA_W(DW), .OPC_W(OW), .OP_SEL_W(SW), .TRF_DEPTH(DEPTH)) i_fault_guard (
    .clk(clk), .rst_n(rst_n), .exValid(exValid), .exOpcode(exOpcode), .exMode(exMode),
    .exRefIdx(exRefIdx), .exResult(exResult), .trfRdData(trfRdData), .trfRdBad(trfRdBad),
    .markFault(markFault), .markOp(markOp), .trfIdx(trfIdx), .trfWrEn(trfWrEn),
    .trfWrData(trfWrData), .trfWrBad(trfWrBad), .knownBad(knownBad),
    .recomputeReq(recomputeReq), .wbEnable(wbEnable), .doubleFault(doubleFault),
    .faultVec(faultVec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural expectation for the slot now applied; then advance the model.
  task automatic checkSlot();
    int sel;
    bit kb, wr, mis, req, wb, dbl, clr;
    sel = int'(exOpcode) / 16;            // upper two of six bits
    kb  = exValid && model[sel];
    wr  = exValid && !exMode;
    mis = (exResult != trfRdData);
    req = exValid && exMode && !kb && !trfRdBad && mis;
    wb  = exValid && !kb && !req;
    dbl = exValid && exMode && kb && trfRdBad;
    clr = exValid && exMode && kb && !trfRdBad && !mis;
    chk(vecTag, 32'(faultVec), 32'(model));
    chk("R2 knownBad", 32'(knownBad), 32'(kb));
    chk("R3 trfWrEn", 32'(trfWrEn), 32'(wr));
    chk("R3 trfIdx", 32'(trfIdx), 32'(exRefIdx));
    if (wr) begin
      chk("R3 trfWrData", 32'(trfWrData), 32'(exResult));
      chk("R3 trfWrBad", 32'(trfWrBad), 32'(kb));
    end
    if (!exValid) chk("R11 quiet", {28'd0, trfWrEn, recomputeReq, wbEnable, doubleFault}, 32'd0);
    else if (kb) chk("R5 recomputeReq", 32'(recomputeReq), 32'(req));
    else if (trfRdBad) chk("R6 recomputeReq", 32'(recomputeReq), 32'(req));
    else chk("R4 recomputeReq", 32'(recomputeReq), 32'(req));
    chk("R7 wbEnable", 32'(wbEnable), 32'(wb));
    chk("R10 doubleFault", 32'(doubleFault), 32'(dbl));
    vecTag = "R11 faultVec hold";
    if (clr) begin model[sel] = 1'b0; vecTag = "R8 faultVec clear"; end
    if (markFault) begin model[markOp] = 1'b1; vecTag = "R9 faultVec mark"; end
  endtask

  task automatic slot(input bit v, input int op, input bit md, input int idx,
                      input int res, input int rd, input bit rb, input bit mk, input int mop);
    @(posedge clk);
    #0.5;
    exValid = v; exOpcode = OW'(op * 16 + (res % 16)); exMode = md; exRefIdx = IW'(idx);
    exResult = DW'(res); trfRdData = DW'(rd); trfRdBad = rb; markFault = mk; markOp = SW'(mop);
    #2;
    checkSlot();
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset faultVec", 32'(faultVec), 32'd0);
    chk("R1 reset strobes", {28'd0, knownBad, trfWrEn, recomputeReq, wbEnable}, 32'd0);
    rst_n = 1'b1;
    slot(0, 0, 0, 0, 0, 0, 0, 0, 0);           // R1 after release
    slot(1, 0, 0, 5, 16'h1234, 0, 0, 0, 0);    // R3 store clean
    slot(1, 1, 1, 5, 16'h0abc, 16'h0abc, 0, 0, 0); // R4 match
    slot(1, 1, 1, 2, 16'h0abc, 16'h0abd, 0, 0, 0); // R4 mismatch -> request, R7 wb held
    slot(1, 1, 1, 2, 16'h0abc, 16'h0abd, 1, 0, 0); // R6 ref bad suppresses
    slot(0, 2, 1, 0, 1, 2, 0, 1, 2);           // R9 mark op2 with idle slot
    slot(1, 2, 0, 7, 16'h00ff, 0, 0, 0, 0);    // R3 store with bad tag, R7 no wb
    slot(1, 2, 1, 7, 16'h00ff, 16'h0f00, 0, 0, 0); // R5 known bad mismatch
    slot(1, 2, 1, 7, 16'h00ff, 16'h00ff, 1, 0, 0); // R10 double fault
    slot(0, 2, 1, 7, 16'h00ff, 16'h00ff, 0, 0, 0); // R11 invalid slot no clear
    slot(1, 2, 1, 7, 16'h00ff, 16'h00ff, 0, 0, 0); // R8 clear transient
    slot(1, 2, 1, 7, 16'h00ff, 16'h0001, 0, 0, 0); // R4 op2 clean again
    slot(0, 3, 0, 0, 0, 0, 0, 1, 3);           // R9 mark op3
    slot(1, 3, 1, 1, 16'h0042, 16'h0042, 0, 1, 3); // R9 mark beats clear
    slot(1, 3, 1, 1, 16'h0042, 16'h0042, 0, 0, 0); // R8 clear now
    slot(1, 3, 0, 1, 16'h0042, 0, 0, 0, 0);    // R2 op3 clean
    for (int n = 0; n < 3000; n++) begin
      int r, d;
      r = int'($urandom_range(0, 255));
      d = ($urandom_range(0, 1) == 0) ? r : int'($urandom_range(0, 255));
      slot($urandom_range(0, 7) != 0, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 7)), r, d, $urandom_range(0, 5) == 0,
           $urandom_range(0, 19) == 0, int'($urandom_range(0, 3)));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule